// File: doc/BRIEF.md
# Encoded Byte Output Port

This block is a latched 8-bit output port that takes its data from the byte at the top of an external stack. On each write strobe, a 2-bit scheme selector sets how that byte changes the pin latch. The byte can be loaded as plain levels. It can be applied as per-bit transition coding, where a 0 bit flips the pin and a 1 bit holds it. It can also drive a single serial bit onto a differential transmit pair wired to a USB transceiver.

In the differential scheme the next transmit state is taken from the received pair, which the transceiver feeds back from the line. The port keeps that state or inverts it depending on the bit being sent. That bit is either bit 0 of the stack byte, because bytes go out LSB first, or a forced stuff bit requested by the command. The upper two pins carry the transceiver's enable and speed controls. Each write can ask for the stack byte to be consumed, and the port answers with a pop pulse.

Top module: `line_out_port`

## Requirements
- R1: After reset, `pins_o` is 8'h00 and `pop_o` is 0.
- R2: A write with scheme 2'b00 or 2'b11 sets `pins_o` to `tos_i` one clock after the strobe. `stuff_i` has no effect in these schemes.
- R3: A write with scheme 2'b01 inverts each `pins_o` bit whose `tos_i` bit is 0 and keeps each bit whose `tos_i` bit is 1. The result appears one clock after the strobe. `stuff_i` has no effect.
- R4: In a cycle without `wr_i`, `pins_o` holds its value whatever the other inputs do, and no pop is issued.
- R5: `pop_o` is high for exactly the one cycle after a write that has `pop_req_i` set, except as limited by R8. It is low in every other cycle.
- R6: A write with scheme 2'b10 sets `pins_o[6]` to 1, sets `pins_o[7]` to the `speed_i` value at the strobe, and clears `pins_o[5:2]`.
- R7: A write with scheme 2'b10 and `stuff_i`=0 sends `tos_i[0]`. The received pair is `rx_pair_i[1]` (Rx+) and `rx_pair_i[0]` (Rx-). If the bit is 1, `pins_o[0]` takes Rx+ and `pins_o[1]` takes Rx-. If the bit is 0, both pins take the inverted values.
- R8: A write with scheme 2'b10 and `stuff_i`=1 sends a 0, so both transmit pins take the inverse of the received pair. `pop_o` stays low even if `pop_req_i` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| scheme_i | input | 2 | Coding scheme: 00/11 level, 01 transition, 10 differential |
| wr_i | input | 1 | Write strobe |
| pop_req_i | input | 1 | Consume the stack byte on this write |
| stuff_i | input | 1 | Send a stuff bit instead of data (scheme 10) |
| tos_i | input | 8 | Top-of-stack byte |
| rx_pair_i | input | 2 | Received pair: [1] Rx+, [0] Rx- |
| speed_i | input | 1 | Speed flag for the transceiver |
| pins_o | output | 8 | Port pins |
| pop_o | output | 1 | One-cycle pop request to the stack |

## Verification
Two functions can meet in the same write: the pop request and the stuff command. They conflict only in scheme 10, where stuffing must suppress the pop. The bench sweeps every combination of scheme, stuff, pop request, received pair and speed over many stack bytes. It expects a pop only when a pop is requested and the write is not a differential stuff. Each write is followed by an idle cycle with scrambled inputs, which checks that the latch holds and that the pop pulse lasts one cycle.

// File: rtl/line_out_pkg.sv
package line_out_pkg;
  typedef enum logic [1:0] {
    SCH_LEVEL = 2'b00,
    SCH_TRANS = 2'b01,
    SCH_DIFF  = 2'b10,
    SCH_ALT   = 2'b11
  } scheme_e;

  function automatic logic is_level(input logic [1:0] s);
    return (s == SCH_LEVEL) || (s == SCH_ALT);
  endfunction
endpackage

// File: rtl/line_rst_sync.sv
module line_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/line_trans_enc.sv
module line_trans_enc #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] nxt_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // a zero data bit marks a transition on its pin
    assign nxt_o[i] = data_i[i] ? cur_i[i] : ~cur_i[i];
  end
endmodule

// File: rtl/line_diff_enc.sv
module line_diff_enc #(
  parameter int W       = 8,
  parameter int TXP_BIT = 0,
  parameter int TXM_BIT = 1,
  parameter int OE_BIT  = 6,
  parameter int SPD_BIT = 7
) (
  input  logic         bit_i,
  input  logic [1:0]   rx_i,
  input  logic         speed_i,
  output logic [W-1:0] nxt_o
);
  logic rx_p, rx_m;
  assign rx_p = rx_i[1];
  assign rx_m = rx_i[0];

  always_comb begin
    nxt_o          = '0;
    nxt_o[TXP_BIT] = bit_i ? rx_p : ~rx_p;
    nxt_o[TXM_BIT] = bit_i ? rx_m : ~rx_m;
    nxt_o[OE_BIT]  = 1'b1;
    nxt_o[SPD_BIT] = speed_i;
  end
endmodule

// File: rtl/line_out_port.sv
module line_out_port
  import line_out_pkg::*;
#(
  parameter int W         = 8,
  parameter int RST_STAGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   scheme_i,
  input  logic         wr_i,
  input  logic         pop_req_i,
  input  logic         stuff_i,
  input  logic [W-1:0] tos_i,
  input  logic [1:0]   rx_pair_i,
  input  logic         speed_i,
  output logic [W-1:0] pins_o,
  output logic         pop_o
);
  localparam int TXP = 0;
  localparam int TXM = 1;
  localparam int OE  = W - 2;
  localparam int SPD = W - 1;

  logic         rst_ni;
  logic [W-1:0] latch_q, latch_d;
  logic [W-1:0] trans_nxt, diff_nxt;
  logic         pop_q, pop_d;
  logic         is_diff, send_bit;

  line_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni)
  );

  assign is_diff  = (scheme_i == SCH_DIFF);
  assign send_bit = stuff_i ? 1'b0 : tos_i[0];

  line_trans_enc #(.W(W)) u_trans (
    .cur_i(latch_q), .data_i(tos_i), .nxt_o(trans_nxt)
  );

  line_diff_enc #(.W(W), .TXP_BIT(TXP), .TXM_BIT(TXM), .OE_BIT(OE), .SPD_BIT(SPD)) u_diff (
    .bit_i(send_bit), .rx_i(rx_pair_i), .speed_i(speed_i), .nxt_o(diff_nxt)
  );

  always_comb begin
    latch_d = latch_q;
    if (wr_i) begin
      unique case (scheme_i)
        SCH_TRANS: latch_d = trans_nxt;
        SCH_DIFF:  latch_d = diff_nxt;
        default:   latch_d = tos_i;
      endcase
    end
    pop_d = wr_i && pop_req_i && !(is_diff && stuff_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      pop_q   <= 1'b0;
    end else begin
      if (wr_i) latch_q <= latch_d;
      pop_q <= pop_d;
    end
  end

  assign pins_o = latch_q;
  assign pop_o  = pop_q;

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_i |=> $stable(pins_o) && !pop_o);

  assert_level_load_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && is_level(scheme_i)) |=> pins_o == $past(tos_i));

  assert_pop_cause_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    pop_o |-> $past(wr_i && pop_req_i));

  assert_diff_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && is_diff) |=> pins_o[OE] && pins_o[SPD] == $past(speed_i) && pins_o[OE-1:TXM+1] == '0);

  assert_stuff_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && is_diff && stuff_i) |=> !pop_o && pins_o[TXP] == !$past(rx_pair_i[1])
                                     && pins_o[TXM] == !$past(rx_pair_i[0]));
endmodule

// File: tb/line_out_port_test.sv
module line_out_port_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] scheme;
  logic       wr, pop_req, stuff, speed;
  logic [7:0] tos;
  logic [1:0] rx;
  logic [7:0] pins;
  logic       pop;

  int vectors = 0;
  int fails   = 0;
  logic [7:0] exp_pins;

  line_out_port uut (
    .clk(clk), .rst_n(rst_n), .scheme_i(scheme), .wr_i(wr), .pop_req_i(pop_req),
    .stuff_i(stuff), .tos_i(tos), .rx_pair_i(rx), .speed_i(speed),
    .pins_o(pins), .pop_o(pop)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pins act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pop act=%0b exp=%0b", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] s, input logic st);
    if (s == 2'b01) return "R3";
    if (s == 2'b10) return st ? "R8" : "R7/R6";
    return "R2";
  endfunction

  initial begin : watchdog
    #(PERIOD * 190000);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    logic bitv;
    logic exp_pop;
    rst_n = 1'b0; wr = 0; pop_req = 0; stuff = 0; speed = 0;
    scheme = 2'b00; tos = 8'h00; rx = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check8("R1", pins, 8'h00);
    check1("R1", pop, 1'b0);
    exp_pins = 8'h00;

    for (int s = 0; s < 4; s++)
      for (int st = 0; st < 2; st++)
        for (int pr = 0; pr < 2; pr++)
          for (int r = 0; r < 4; r++)
            for (int sp = 0; sp < 2; sp++)
              for (int k = 0; k < 64; k++) begin
                scheme  = 2'(s);
                stuff   = 1'(st);
                pop_req = 1'(pr);
                rx      = 2'(r);
                speed   = 1'(sp);
                tos     = 8'((k * 73 + 11 + s * 5 + r) & 255);
                wr      = 1'b1;
                // expected values from the requirements
                case (scheme)
                  2'b01: exp_pins = exp_pins ^ ~tos;
                  2'b10: begin
                    bitv = stuff ? 1'b0 : tos[0];
                    exp_pins = {speed, 1'b1, 4'b0000,
                                bitv ? rx[0] : ~rx[0],
                                bitv ? rx[1] : ~rx[1]};
                  end
                  default: exp_pins = tos;
                endcase
                exp_pop = pop_req && !(scheme == 2'b10 && stuff);
                @(negedge clk);
                check8(req_of(scheme, stuff), pins, exp_pins);
                check1(exp_pop ? "R5" : "R5/R8", pop, exp_pop);
                // idle cycle with scrambled inputs (R4, pulse width R5)
                wr = 1'b0; pop_req = 1'b1; stuff = ~stuff; tos = ~tos;
                rx = ~rx; speed = ~speed; scheme = ~scheme;
                @(negedge clk);
                check8("R4", pins, exp_pins);
                check1("R4", pop, 1'b0);
              end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule